// File: doc/BRIEF.md
# Switchable ROM/RAM Bank Controller

This block watches processor writes into the read-only program area of a 16-bit address space and interprets them as control writes. The top three address bits pick one of four control regions. The block holds the selected bank for the switchable program-ROM window, the selected external-RAM bank, and a gate that allows or blocks access to external RAM. The surrounding memory system uses these outputs to form the upper address bits of the ROM and RAM arrays.

Two registers form the ROM bank number: a 5-bit low field and a 2-bit shared field. A mode flag steers the shared field. In mode 0 it supplies ROM bank bits 6:5. In mode 1 it selects the RAM bank instead. A log2 bank-count input describes the installed ROM. The ROM bank number on the output is masked to that size, so an out-of-range selection wraps back into the device.

Top module: `cart_bank_ctrl`

## Requirements
- R1: During reset and immediately after it, the ROM bank output is 1 (when the ROM holds at least two banks), the RAM bank output is 0, the RAM gate is closed (0), and the mode is 0.
- R2: A write with addr[15:13] = 0 opens the RAM gate when the data is 0x0A and closes it when the data is 0x00. Any other data leaves the gate unchanged.
- R3: A write with addr[15:13] = 1 loads data[4:0] into ROM bank bits 4:0 and leaves bits 6:5 unchanged. A zero in data[4:0] is stored as 1.
- R4: A write with addr[15:13] = 2 in mode 0 loads data[1:0] into ROM bank bits 6:5 and leaves the RAM bank unchanged.
- R5: A write with addr[15:13] = 2 in mode 1 loads data[1:0] into the RAM bank and leaves the ROM bank unchanged.
- R6: A write with addr[15:13] = 3 sets the mode to data[0]. Writing mode 1 clears ROM bank bits 6:5. Writing mode 0 forces the RAM bank to 0. In mode 0 the RAM bank is always 0.
- R7: The ROM bank output equals the stored 7-bit bank number ANDed with (2^rom_size_log2 - 1). When rom_size_log2 is 7 or more, all 7 bits pass. The stored number is not changed by the mask.
- R8: A write with addr[15] = 1 has no effect on any output or stored field. Neither does any cycle with wr_en low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; control writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Processor write strobe, one cycle per write |
| addr | input | 16 | Processor write address |
| wdata | input | 8 | Processor write data |
| rom_size_log2 | input | 4 | log2 of the installed ROM size counted in 16 KiB banks |
| rom_bank | output | 7 | Bank for the switchable ROM window, wrapped to the ROM size |
| ram_bank | output | 2 | Selected external-RAM bank |
| ram_en | output | 1 | External RAM access gate |

## Verification
The vector walk writes the low field with zero, with values that carry stray upper bits (0xE4, 0x20), and with all ones. This separates the zero-to-one substitution from plain truncation, and it confirms that bits 6:5 survive each write. Writes to the shared field are issued in both modes, and the mode is toggled each way. This tells steering to the ROM apart from steering to the RAM, and shows each side effect of a mode write. The gate is tried with 0x0A, 0x00 and an unrelated value, at the lowest and highest offsets of its region. Writes above 0x7FFF and idle cycles with data on the bus must leave everything unchanged. The ROM size input is swept across 0, 1, 3, 4, 7 and 9 with a high stored bank, which exposes wrap, pass-through and the zero-bank edge.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int REGION_W   = 3;
    localparam int LOW_W      = 5;
    localparam int HIGH_W     = 2;
    localparam int ROM_BANK_W = LOW_W + HIGH_W;
    localparam int RAM_BANK_W = HIGH_W;
    localparam int SIZE_W     = 4;

    typedef enum logic [1:0] {
        RGN_RAM_GATE = 2'd0,
        RGN_ROM_LOW  = 2'd1,
        RGN_SHARED   = 2'd2,
        RGN_MODE     = 2'd3
    } region_e;

    typedef struct packed {
        logic                  ram_on;
        logic                  mode;
        logic [LOW_W-1:0]      low;
        logic [HIGH_W-1:0]     high;
        logic [RAM_BANK_W-1:0] ram_sel;
    } bank_state_t;
endpackage

// File: rtl/cart_wr_decode.sv
module cart_wr_decode
    import cart_bank_pkg::*;
(
    input  logic                wr_en,
    input  logic [REGION_W-1:0] top_bits,
    output logic                hit,
    output region_e             region
);
    // Only the lower half of the address space holds control regions
    assign hit    = wr_en && !top_bits[REGION_W-1];
    assign region = region_e'(top_bits[1:0]);
endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
    import cart_bank_pkg::*;
#(
    parameter logic [DATA_W-1:0] ENABLE_KEY  = 8'h0A,
    parameter logic [DATA_W-1:0] DISABLE_KEY = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  region_e           region,
    input  logic [DATA_W-1:0] wdata,
    output bank_state_t       state_q
);
    localparam bank_state_t RESET_STATE = '{
        ram_on:  1'b0,
        mode:    1'b0,
        low:     LOW_W'(1),
        high:    '0,
        ram_sel: '0
    };

    bank_state_t      state_d;
    logic [LOW_W-1:0] low_field;

    assign low_field = wdata[LOW_W-1:0];

    always_comb begin
        state_d = state_q;
        if (hit) begin
            unique case (region)
                RGN_RAM_GATE: begin
                    if (wdata == ENABLE_KEY)       state_d.ram_on = 1'b1;
                    else if (wdata == DISABLE_KEY) state_d.ram_on = 1'b0;
                end
                RGN_ROM_LOW: begin
                    state_d.low = (low_field == '0) ? LOW_W'(1) : low_field;
                end
                RGN_SHARED: begin
                    if (state_q.mode) state_d.ram_sel = wdata[RAM_BANK_W-1:0];
                    else              state_d.high    = wdata[HIGH_W-1:0];
                end
                RGN_MODE: begin
                    state_d.mode = wdata[0];
                    if (wdata[0]) state_d.high    = '0;
                    else          state_d.ram_sel = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RESET_STATE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/cart_rom_wrap.sv
module cart_rom_wrap #(
    parameter int BANK_W = 7,
    parameter int SIZE_W = 4
) (
    input  logic [BANK_W-1:0] raw_bank,
    input  logic [SIZE_W-1:0] size_log2,
    output logic [BANK_W-1:0] bank
);
    logic [BANK_W-1:0] mask;

    // Bit i survives when the ROM holds more than 2^i banks
    for (genvar i = 0; i < BANK_W; i++) begin : g_mask
        assign mask[i] = (size_log2 > SIZE_W'(i));
    end

    assign bank = raw_bank & mask;
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cart_bank_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [SIZE_W-1:0]     rom_size_log2,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic                  ram_en
);
    logic                  hit;
    region_e               region;
    bank_state_t           state_q;
    logic [ROM_BANK_W-1:0] raw_bank;
    logic                  mode_q;
    logic                  unused_addr;

    assign unused_addr = ^addr[ADDR_W-REGION_W-1:0];

    cart_wr_decode u_decode (
        .wr_en    (wr_en),
        .top_bits (addr[ADDR_W-1 -: REGION_W]),
        .hit      (hit),
        .region   (region)
    );

    cart_bank_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .region  (region),
        .wdata   (wdata),
        .state_q (state_q)
    );

    assign raw_bank = {state_q.high, state_q.low};
    assign mode_q   = state_q.mode;

    cart_rom_wrap #(
        .BANK_W (ROM_BANK_W),
        .SIZE_W (SIZE_W)
    ) u_wrap (
        .raw_bank  (raw_bank),
        .size_log2 (rom_size_log2),
        .bank      (rom_bank)
    );

    assign ram_bank = state_q.ram_sel;
    assign ram_en   = state_q.ram_on;
endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk
    import cart_bank_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     addr,
    input logic [DATA_W-1:0]     wdata,
    input logic [SIZE_W-1:0]     rom_size_log2,
    input logic [ROM_BANK_W-1:0] rom_bank,
    input logic [RAM_BANK_W-1:0] ram_bank,
    input logic                  ram_en,
    input logic [ROM_BANK_W-1:0] raw_bank,
    input logic                  mode_q
);
    logic [REGION_W-1:0] rgn;
    assign rgn = addr[ADDR_W-1 -: REGION_W];

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (raw_bank == ROM_BANK_W'(1) && ram_bank == '0 && !ram_en && !mode_q));

    assert_gate_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rgn == 3'd0 && wdata == 8'h0A) |=> ram_en);

    assert_gate_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rgn == 3'd0 && wdata == 8'h00) |=> !ram_en);

    assert_zero_remap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rgn == 3'd1 && wdata[LOW_W-1:0] == '0) |=> raw_bank[LOW_W-1:0] == LOW_W'(1));

    assert_high_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rgn == 3'd2 && !mode_q) |=> raw_bank[ROM_BANK_W-1:LOW_W] == $past(wdata[HIGH_W-1:0]));

    assert_ram_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rgn == 3'd2 && mode_q) |=> (ram_bank == $past(wdata[RAM_BANK_W-1:0]) && $stable(raw_bank)));

    assert_mode_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rgn == 3'd3 && wdata[0]) |=> (mode_q && raw_bank[ROM_BANK_W-1:LOW_W] == '0));

    assert_mode_zero_ram_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> ram_bank == '0);

    assert_wrap_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_size_log2 < SIZE_W'(ROM_BANK_W)) |->
        ({1'b0, rom_bank} < ({{ROM_BANK_W{1'b0}}, 1'b1} << rom_size_log2)));

    assert_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || addr[ADDR_W-1]) |=>
        ($stable(raw_bank) && $stable(ram_bank) && $stable(ram_en) && $stable(mode_q)));
endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .addr          (addr),
    .wdata         (wdata),
    .rom_size_log2 (rom_size_log2),
    .rom_bank      (rom_bank),
    .ram_bank      (ram_bank),
    .ram_en        (ram_en),
    .raw_bank      (raw_bank),
    .mode_q        (mode_q)
);

// File: tb/tb_cart_bank_ctrl.sv
module tb_cart_bank_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = 16'h0;
    logic [7:0]  wdata = 8'h0;
    logic [3:0]  rom_size_log2 = 4'd7;
    logic [6:0]  rom_bank;
    logic [1:0]  ram_bank;
    logic        ram_en;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    cart_bank_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .addr          (addr),
        .wdata         (wdata),
        .rom_size_log2 (rom_size_log2),
        .rom_bank      (rom_bank),
        .ram_bank      (ram_bank),
        .ram_en        (ram_en)
    );

    typedef struct packed {
        logic [15:0] a;
        logic [7:0]  d;
        logic [3:0]  s;
        logic [6:0]  rom;
        logic [1:0]  ram;
        logic        en;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{16'h0000, 8'h0A, 4'd7, 7'h01, 2'd0, 1'b1, 4'd2}, // R2 open
        '{16'h1FFF, 8'h55, 4'd7, 7'h01, 2'd0, 1'b1, 4'd2}, // R2 other value holds
        '{16'h0100, 8'h00, 4'd7, 7'h01, 2'd0, 1'b0, 4'd2}, // R2 close
        '{16'h2000, 8'h00, 4'd7, 7'h01, 2'd0, 1'b0, 4'd3}, // R3 zero -> 1
        '{16'h3FFF, 8'h13, 4'd7, 7'h13, 2'd0, 1'b0, 4'd3}, // R3 load
        '{16'h4000, 8'h02, 4'd7, 7'h53, 2'd0, 1'b0, 4'd4}, // R4 high bits
        '{16'h2000, 8'hE4, 4'd7, 7'h44, 2'd0, 1'b0, 4'd3}, // R3 keeps 6:5
        '{16'h2000, 8'h20, 4'd7, 7'h41, 2'd0, 1'b0, 4'd3}, // R3 stray bit, zero low
        '{16'h6000, 8'h01, 4'd7, 7'h01, 2'd0, 1'b0, 4'd6}, // R6 mode 1 clears high
        '{16'h4000, 8'h03, 4'd7, 7'h01, 2'd3, 1'b0, 4'd5}, // R5 ram select
        '{16'h5FFF, 8'hFE, 4'd7, 7'h01, 2'd2, 1'b0, 4'd5}, // R5 ram select
        '{16'h8000, 8'h0A, 4'd7, 7'h01, 2'd2, 1'b0, 4'd8}, // R8 ignored
        '{16'hA000, 8'h00, 4'd7, 7'h01, 2'd2, 1'b0, 4'd8}, // R8 ignored
        '{16'hE000, 8'h0A, 4'd7, 7'h01, 2'd2, 1'b0, 4'd8}, // R8 ignored
        '{16'h7FFF, 8'hFE, 4'd7, 7'h01, 2'd0, 1'b0, 4'd6}, // R6 mode 0 clears ram
        '{16'h4000, 8'h01, 4'd7, 7'h21, 2'd0, 1'b0, 4'd4}, // R4
        '{16'h2000, 8'h1F, 4'd7, 7'h3F, 2'd0, 1'b0, 4'd3}, // R3
        '{16'h6000, 8'h03, 4'd7, 7'h1F, 2'd0, 1'b0, 4'd6}, // R6
        '{16'h6000, 8'h00, 4'd7, 7'h1F, 2'd0, 1'b0, 4'd6}, // R6
        '{16'h4000, 8'h03, 4'd7, 7'h7F, 2'd0, 1'b0, 4'd4}, // R4
        '{16'h8000, 8'h00, 4'd3, 7'h07, 2'd0, 1'b0, 4'd7}, // R7 wrap 8 banks
        '{16'h2000, 8'h0A, 4'd3, 7'h02, 2'd0, 1'b0, 4'd7}, // R7 raw 0x6A
        '{16'h2000, 8'h10, 4'd4, 7'h00, 2'd0, 1'b0, 4'd7}, // R7 raw 0x70
        '{16'h2000, 8'h00, 4'd1, 7'h01, 2'd0, 1'b0, 4'd7}, // R7 raw 0x61
        '{16'h2000, 8'h02, 4'd0, 7'h00, 2'd0, 1'b0, 4'd7}, // R7 raw 0x62
        '{16'h2000, 8'h05, 4'd9, 7'h65, 2'd0, 1'b0, 4'd7}  // R7 full pass
    };

    task automatic check(input string tag, input logic [6:0] erom,
                         input logic [1:0] eram, input logic een);
        checks++;
        if (rom_bank !== erom || ram_bank !== eram || ram_en !== een) begin
            fails++;
            $display("FAIL %s: rom=%h ram=%0d en=%0b expected rom=%h ram=%0d en=%0b",
                     tag, rom_bank, ram_bank, ram_en, erom, eram, een);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic [3:0] s);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; rom_size_log2 = s;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset held", 7'h01, 2'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 7'h01, 2'd0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i].a, VEC[i].d, VEC[i].s);
            check($sformatf("R%0d vector %0d", VEC[i].req, i),
                  VEC[i].rom, VEC[i].ram, VEC[i].en);
        end

        // R8: bus activity without the strobe changes nothing
        rom_size_log2 = 4'd7;
        @(negedge clk);
        addr = 16'h0000; wdata = 8'h0A;
        repeat (2) @(negedge clk);
        check("R8 strobe low", 7'h65, 2'd0, 1'b0);
        addr = 16'h6000; wdata = 8'h01;
        repeat (2) @(negedge clk);
        check("R8 strobe low mode", 7'h65, 2'd0, 1'b0);

        // R1: reset in the middle of a run
        do_write(16'h0000, 8'h0A, 4'd7);
        do_write(16'h6000, 8'h01, 4'd7);
        do_write(16'h4000, 8'h02, 4'd7);
        check("R5 before reset", 7'h05, 2'd2, 1'b1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 mid-run reset", 7'h01, 2'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: mode is 0 after reset, so region 2 steers to the ROM bank
        do_write(16'h4000, 8'h01, 4'd7);
        check("R1 mode 0 after reset", 7'h21, 2'd0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule